// File: doc/BRIEF.md
# Cascadable LCD Segment Driver Core

This block is the digital heart of an 80-column LCD segment driver. Several of these drivers can be chained along one 4-bit display bus. A controller sends nibbles on the falling edges of a shift clock. Only the chip that currently holds the enable takes them. When that chip has 80 bits, it raises its enable output on its own, and the next chip in the chain takes over. No address or select lines are needed. While a chip is not enabled, or once it is full, its internal shift strobe and data bus are held at zero, so its data register stays still.

A falling edge of the latch pulse copies the data register into the output latch. The same edge drops the enable output, which re-arms the chain for the next line. Each column then carries a 2-bit code that selects one of four drive voltages. The code depends on the latched bit, the frame-alternation input and an active-low blank input. A direction pin mirrors the order in which columns are filled, and it also decides which of the two chain pins is the input and which is the output.

All logic runs on one system clock. The shift clock, latch pulse, data nibble and selected enable input go through a common synchronizer, so they stay aligned. Edges are detected on the synchronized copies.

Top module: `seg_drv_core`

## Requirements
- R1: Each recognised falling edge of `shclk_i` captures one 4-bit nibble from `nib_i`, provided the chip is enabled and not yet full. Twenty captures fill the 80 columns.
- R2: With `dir_i` low, bit j (0..3) of the k-th captured nibble (k from 0) is stored in column 76 - 4k + j. So the first nibble's bit 3 lands in column 79, and filling proceeds downward.
- R3: With `dir_i` high, bit j of the k-th nibble is stored in column 4k + 3 - j. So the first nibble's bit 3 lands in column 0, and filling proceeds upward.
- R4: With `dir_i` low, `chain_b_i` is the enable input and pin A is the driven output (`chain_a_oe`=1, `chain_b_oe`=0). With `dir_i` high the roles swap. The undriven pin's output value is 0, and the unselected input is ignored.
- R5: The enable output of the active output pin follows these rules:
  - It is low after reset.
  - It goes high after the 20th capture of a line.
  - It stays high until the next latch edge, which clears it.
  - While it is high, further shift edges are ignored.
- R6: While the selected enable input is low, shift edges capture nothing and the data register keeps its contents.
- R7: A falling edge of `latch_i` copies all 80 data-register bits into the output latch. Between latch edges the latch, and so `lvl_o` for fixed `alt_i`/`blank_n_i`, does not change.
- R8: While `blank_n_i` is low, every column of `lvl_o` is 2'b00, whatever the latch and `alt_i` hold.
- R9: While `blank_n_i` is high, the column code depends on the latched bit and `alt_i`, and is combinational from those inputs. The codes are 00 = V0, 01 = V2, 10 = V3, 11 = V5:

  | Latched bit | `alt_i` | Code |
  |---|---|---|
  | 1 | 1 | 2'b00 (V0) |
  | 1 | 0 | 2'b11 (V5) |
  | 0 | 1 | 2'b01 (V2) |
  | 0 | 0 | 2'b10 (V3) |

- R10: Asynchronous active-low reset clears the nibble count, the full flag, the data register and the output latch. After reset every column shows the code for a latched 0.
- R11: A latch edge and a shift edge recognised in the same cycle are handled latch-first. The latch receives the old register contents and the chain is re-armed. The simultaneous nibble is then captured as nibble 0 of the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shclk_i | input | 1 | Display shift clock; data taken on its falling edge |
| latch_i | input | 1 | Latch pulse; register copied to latch on its falling edge |
| nib_i | input | 4 | Display data nibble |
| dir_i | input | 1 | Fill direction and chain pin role select |
| alt_i | input | 1 | Frame-alternation signal |
| blank_n_i | input | 1 | Forced blank, active low |
| chain_a_i | input | 1 | Chain pin A, input side (enable in when `dir_i`=1) |
| chain_b_i | input | 1 | Chain pin B, input side (enable in when `dir_i`=0) |
| chain_a_o | output | 1 | Chain pin A, output value |
| chain_a_oe | output | 1 | Chain pin A, output enable |
| chain_b_o | output | 1 | Chain pin B, output value |
| chain_b_oe | output | 1 | Chain pin B, output enable |
| lvl_o | output | 160 | Per-column drive code, column c at bits [2c+1:2c] |

## Verification
The latch transfer and a nibble capture can land in the same system cycle. The bench provokes this by dropping `shclk_i` and `latch_i` on the same clock so that both pass through the synchronizer together. It then judges the outcome in three ways:
- The following latch must hold the previous line's data.
- The enable output must rise after only nineteen further nibbles.
- The next latch must show the simultaneous nibble at the first-fill position.

Random frames with enable gaps, both directions and extra shifts past full are compared column by column against a bench model under all four blank/alternation combinations.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V3 = 2'b10,
    LVL_V5 = 2'b11
  } seg_lvl_e;

  // Drive code from latched bit, alternation phase and active-low blank.
  function automatic seg_lvl_e lvl_code(input logic bit_on, input logic alt,
                                        input logic blank_n);
    seg_lvl_e r;
    if (!blank_n)    r = LVL_V0;
    else if (bit_on) r = alt ? LVL_V0 : LVL_V5;
    else             r = alt ? LVL_V2 : LVL_V3;
    return r;
  endfunction

  // Which nibble slot fills column col, for a given direction.
  function automatic int nib_of_col(input int col, input int ncols,
                                    input int nw, input logic dir);
    return dir ? (col / nw) : ((ncols - 1 - col) / nw);
  endfunction

  // Which nibble lane (bit of the bus) fills column col.
  function automatic int lane_of_col(input int col, input int nw,
                                     input logic dir);
    return dir ? (nw - 1 - (col % nw)) : (col % nw);
  endfunction

endpackage

// File: rtl/seg_in_sync.sv
module seg_in_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/seg_chain_ctl.sv
module seg_chain_ctl #(
  parameter int NUM_NIBS = 20,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_s,
  input  logic             lat_s,
  input  logic             en_s,
  output logic             cap_evt,
  output logic             lat_evt,
  output logic [CNT_W-1:0] wr_idx,
  output logic             full_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_NIBS - 1);

  logic             sh_prev, lat_prev;
  logic             sh_fall;
  logic [CNT_W-1:0] cnt_q;
  logic             full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_prev  <= 1'b0;
      lat_prev <= 1'b0;
    end else begin
      sh_prev  <= sh_s;
      lat_prev <= lat_s;
    end
  end

  assign sh_fall = sh_prev & ~sh_s;
  assign lat_evt = lat_prev & ~lat_s;

  // Latch-first: a latch in this cycle re-arms before the shift is judged.
  assign full_eff = full_q & ~lat_evt;
  assign wr_idx   = lat_evt ? '0 : cnt_q;
  assign cap_evt  = sh_fall & en_s & ~full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (cap_evt) begin
      if (wr_idx == LAST) begin
        cnt_q  <= '0;
        full_q <= 1'b1;
      end else begin
        cnt_q  <= wr_idx + 1'b1;
        full_q <= 1'b0;
      end
    end else if (lat_evt) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_data_reg.sv
module seg_data_reg
  import seg_drv_pkg::*;
#(
  parameter int NUM_COLS = 80,
  parameter int NIB_W    = 4,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_evt,
  input  logic                dir,
  input  logic [CNT_W-1:0]    wr_idx,
  input  logic [NIB_W-1:0]    nib,
  output logic [NUM_COLS-1:0] data_q
);

  logic [NUM_COLS-1:0] col_we;
  logic [NUM_COLS-1:0] col_nb;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int K_DN = nib_of_col(c, NUM_COLS, NIB_W, 1'b0);
    localparam int J_DN = lane_of_col(c, NIB_W, 1'b0);
    localparam int K_UP = nib_of_col(c, NUM_COLS, NIB_W, 1'b1);
    localparam int J_UP = lane_of_col(c, NIB_W, 1'b1);
    logic hit_dn, hit_up;
    assign hit_dn    = (wr_idx == CNT_W'(K_DN));
    assign hit_up    = (wr_idx == CNT_W'(K_UP));
    assign col_we[c] = cap_evt & (dir ? hit_up : hit_dn);
    assign col_nb[c] = dir ? nib[J_UP] : nib[J_DN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= (data_q & ~col_we) | (col_nb & col_we);
  end

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_drv_pkg::*;
#(
  parameter int NUM_COLS = 80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lat_evt,
  input  logic [NUM_COLS-1:0]   data_q,
  input  logic                  alt,
  input  logic                  blank_n,
  output logic [NUM_COLS-1:0]   latch_q,
  output logic [2*NUM_COLS-1:0] lvl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (lat_evt) latch_q <= data_q;
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_lvl
    assign lvl[2*c +: 2] = lvl_code(latch_q[c], alt, blank_n);
  end

endmodule

// File: rtl/seg_drv_core.sv
module seg_drv_core #(
  parameter int NUM_COLS    = 80,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shclk_i,
  input  logic                  latch_i,
  input  logic [NIB_W-1:0]      nib_i,
  input  logic                  dir_i,
  input  logic                  alt_i,
  input  logic                  blank_n_i,
  input  logic                  chain_a_i,
  input  logic                  chain_b_i,
  output logic                  chain_a_o,
  output logic                  chain_a_oe,
  output logic                  chain_b_o,
  output logic                  chain_b_oe,
  output logic [2*NUM_COLS-1:0] lvl_o
);

  localparam int NUM_NIBS = NUM_COLS / NIB_W;
  localparam int CNT_W    = (NUM_NIBS > 1) ? $clog2(NUM_NIBS) : 1;
  localparam int SYNC_W   = NIB_W + 3;

  logic                en_raw;
  logic [SYNC_W-1:0]   sync_q;
  logic                sh_s, lat_s, en_s;
  logic [NIB_W-1:0]    nib_s;
  logic [NIB_W-1:0]    nib_gated;
  logic                cap_evt, lat_evt, full_q;
  logic [CNT_W-1:0]    wr_idx;
  logic [NUM_COLS-1:0] data_q;
  logic [NUM_COLS-1:0] latch_q;

  assign en_raw = dir_i ? chain_a_i : chain_b_i;

  seg_in_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nib_i, en_raw, latch_i, shclk_i}),
    .q     (sync_q)
  );

  assign sh_s  = sync_q[0];
  assign lat_s = sync_q[1];
  assign en_s  = sync_q[2];
  assign nib_s = sync_q[3 +: NIB_W];

  seg_chain_ctl #(.NUM_NIBS(NUM_NIBS), .CNT_W(CNT_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sh_s    (sh_s),
    .lat_s   (lat_s),
    .en_s    (en_s),
    .cap_evt (cap_evt),
    .lat_evt (lat_evt),
    .wr_idx  (wr_idx),
    .full_q  (full_q)
  );

  // Internal bus is held low unless this cycle captures.
  assign nib_gated = cap_evt ? nib_s : '0;

  seg_data_reg #(.NUM_COLS(NUM_COLS), .NIB_W(NIB_W), .CNT_W(CNT_W)) u_dreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_evt (cap_evt),
    .dir     (dir_i),
    .wr_idx  (wr_idx),
    .nib     (nib_gated),
    .data_q  (data_q)
  );

  seg_out_stage #(.NUM_COLS(NUM_COLS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .lat_evt (lat_evt),
    .data_q  (data_q),
    .alt     (alt_i),
    .blank_n (blank_n_i),
    .latch_q (latch_q),
    .lvl     (lvl_o)
  );

  assign chain_a_oe = ~dir_i;
  assign chain_b_oe = dir_i;
  assign chain_a_o  = ~dir_i & full_q;
  assign chain_b_o  = dir_i & full_q;

endmodule

// File: rtl/seg_drv_chk.sv
module seg_drv_chk #(
  parameter int NUM_COLS = 80,
  parameter int CNT_W    = 5,
  parameter int NUM_NIBS = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cap_evt,
  input logic                  lat_evt,
  input logic                  full_q,
  input logic [CNT_W-1:0]      wr_idx,
  input logic [NUM_COLS-1:0]   data_q,
  input logic [NUM_COLS-1:0]   latch_q,
  input logic                  blank_n_i,
  input logic                  chain_a_oe,
  input logic                  chain_b_oe,
  input logic [2*NUM_COLS-1:0] lvl_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_NIBS - 1);

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx <= LAST); // R1

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({chain_a_oe, chain_b_oe}) == 1); // R4

  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> ($past(cap_evt) && $past(wr_idx) == LAST)); // R5

  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lat_evt |=> !full_q); // R5

  AST_NO_CAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !lat_evt) |-> !cap_evt); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(data_q)); // R6

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    lat_evt |=> (latch_q == $past(data_q))); // R7

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_evt |=> $stable(latch_q)); // R7

  AST_BLANK_V0: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n_i |-> (lvl_o == '0)); // R8

endmodule

bind seg_drv_core seg_drv_chk #(
  .NUM_COLS (NUM_COLS),
  .CNT_W    (CNT_W),
  .NUM_NIBS (NUM_NIBS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_evt    (cap_evt),
  .lat_evt    (lat_evt),
  .full_q     (full_q),
  .wr_idx     (wr_idx),
  .data_q     (data_q),
  .latch_q    (latch_q),
  .blank_n_i  (blank_n_i),
  .chain_a_oe (chain_a_oe),
  .chain_b_oe (chain_b_oe),
  .lvl_o      (lvl_o)
);

// File: tb/seg_drv_core_bench.sv
module seg_drv_core_bench;

  localparam int NC = 80;
  localparam int NW = 4;
  localparam int NN = NC / NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shclk_i = 1'b1, latch_i = 1'b1;
  logic [NW-1:0] nib_i = '0;
  logic          dir_i = 1'b0, alt_i = 1'b0, blank_n_i = 1'b1;
  logic          chain_a_i = 1'b0, chain_b_i = 1'b0;
  logic          chain_a_o, chain_a_oe, chain_b_o, chain_b_oe;
  logic [2*NC-1:0] lvl_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [NC-1:0] m_data = '0, m_lat = '0;
  int  m_cnt = 0;
  bit  m_full = 0, en_drv = 0;

  always #4 clk = ~clk;

  seg_drv_core u_seg_drv_core (
    .clk(clk), .rst_n(rst_n), .shclk_i(shclk_i), .latch_i(latch_i),
    .nib_i(nib_i), .dir_i(dir_i), .alt_i(alt_i), .blank_n_i(blank_n_i),
    .chain_a_i(chain_a_i), .chain_b_i(chain_b_i),
    .chain_a_o(chain_a_o), .chain_a_oe(chain_a_oe),
    .chain_b_o(chain_b_o), .chain_b_oe(chain_b_oe), .lvl_o(lvl_o));

  function automatic logic [1:0] exp_code(logic b, logic alt, logic bn);
    logic [1:0] r;
    if (!bn) r = 2'b00;
    else case ({b, alt})
      2'b11: r = 2'b00;
      2'b10: r = 2'b11;
      2'b01: r = 2'b01;
      default: r = 2'b10;
    endcase
    return r;
  endfunction

  function automatic logic [2*NC-1:0] exp_bus(logic [NC-1:0] l, logic alt, logic bn);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++) r[2*c +: 2] = exp_code(l[c], alt, bn);
    return r;
  endfunction

  function automatic int col_for(int k, int j, logic d);
    return d ? (4*k + 3 - j) : (76 - 4*k + j);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [2*NC-1:0] act, logic [2*NC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_levels(string req);
    logic sa = alt_i, sb = blank_n_i;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 2; a++) begin
        blank_n_i = b[0]; alt_i = a[0];
        #1;
        chk(req, lvl_o, exp_bus(m_lat, a[0], b[0]));
      end
    alt_i = sa; blank_n_i = sb;
    #1;
  endtask

  task automatic chk_chain(string req);
    logic [3:0] e;
    e = {~dir_i, ~dir_i & m_full, dir_i, dir_i & m_full};
    chk(req, {{(2*NC-4){1'b0}}, chain_a_oe, chain_a_o, chain_b_oe, chain_b_o},
        {{(2*NC-4){1'b0}}, e});
  endtask

  task automatic set_en(bit e);
    en_drv = e;
    if (dir_i) begin chain_a_i = e; chain_b_i = ~e; end
    else       begin chain_b_i = e; chain_a_i = ~e; end
  endtask

  task automatic set_dir(bit d);
    dir_i = d;
    set_en(en_drv);
    tick(4);
  endtask

  task automatic model_cap(logic [NW-1:0] n);
    if (en_drv && !m_full) begin
      for (int j = 0; j < NW; j++) m_data[col_for(m_cnt, j, dir_i)] = n[j];
      if (m_cnt == NN-1) begin m_cnt = 0; m_full = 1; end
      else m_cnt++;
    end
  endtask

  task automatic shift_nib(logic [NW-1:0] n);
    nib_i = n; tick(2);
    shclk_i = 1'b0; tick(4);
    shclk_i = 1'b1; tick(2);
    model_cap(n);
  endtask

  task automatic latch_pulse();
    tick(1);
    latch_i = 1'b0; tick(5);
    latch_i = 1'b1; tick(1);
    m_lat = m_data; m_cnt = 0; m_full = 0;
  endtask

  task automatic shift_and_latch(logic [NW-1:0] n);
    nib_i = n; tick(2);
    shclk_i = 1'b0; latch_i = 1'b0; tick(5);
    shclk_i = 1'b1; latch_i = 1'b1; tick(2);
    m_lat = m_data; m_cnt = 0; m_full = 0;
    model_cap(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R10: reset state
    chk_levels("R10");
    chk_chain("R5 reset");

    // R2: directed downward fill, first nibble 4'h8 -> column 79 only
    set_en(1); set_dir(0);
    shift_nib(4'h8);
    for (int k = 1; k < NN; k++) shift_nib(4'h0);
    latch_pulse();
    chk("R2", lvl_o, {2'b11, {(NC-1){2'b10}}});

    // R3: directed upward fill -> column 0 only
    set_dir(1);
    shift_nib(4'h8);
    for (int k = 1; k < NN; k++) shift_nib(4'h0);
    latch_pulse();
    chk("R3", lvl_o, {{(NC-1){2'b10}}, 2'b11});
    chk_chain("R4 dir high");

    // R1/R5/R7: random downward frame, enable timing and hold before latch
    set_dir(0);
    chk_chain("R4 dir low");
    for (int k = 0; k < NN; k++) begin
      shift_nib(4'($urandom));
      if (k == NN-2) chk_chain("R5 before last");
      if (k == NN-1) chk_chain("R1 full after 20");
    end
    chk_levels("R7 hold before latch");
    shift_nib(4'hF);   // ignored while full
    shift_nib(4'hA);
    chk_chain("R5 stays high");
    latch_pulse();
    chk_chain("R5 cleared by latch");
    chk_levels("R9");

    // R6: enable low ignores shifts
    set_en(0);
    for (int k = 0; k < 5; k++) shift_nib(4'($urandom));
    chk_chain("R6 no progress");
    set_en(1);
    for (int k = 0; k < NN; k++) shift_nib(4'($urandom));
    chk_chain("R6 full after enable");
    latch_pulse();
    chk_levels("R6");

    // R11: simultaneous latch and shift, latch-first
    for (int k = 0; k < 7; k++) shift_nib(4'($urandom));
    shift_and_latch(4'hD);
    chk_levels("R11 old data latched");
    for (int k = 0; k < NN-2; k++) shift_nib(4'($urandom));
    chk_chain("R11 not yet full");
    shift_nib(4'($urandom));
    chk_chain("R11 full after 19 more");
    latch_pulse();
    chk_levels("R11 new line");

    // R8/R9/R4: random frames with enable gaps and both directions
    for (int f = 0; f < 6; f++) begin
      set_dir(1'($urandom));
      for (int k = 0; k < NN + 4; k++) begin
        set_en(($urandom % 5) != 0);
        shift_nib(4'($urandom));
      end
      chk_chain("R4 random");
      latch_pulse();
      chk_levels("R8 R9 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule